// File: doc/BRIEF.md
# Multiplexed Status-Coded Bus Cycle Master

This block runs one bus transaction at a time on an 8-bit multiplexed address/data bus. The transaction type is announced to an external bus controller through a 3-bit status code. A user-side request carries a status code, a 20-bit address and, for write types, one data byte. The block places the address on its split address outputs and on the shared low byte. It then drives the status active through the T1, T2 and T3/Tw states. It stays in T3/Tw for as long as READY is sampled low. After that it returns the status to passive in T4 and goes back to idle.

For the read types, the byte on the shared bus is captured on the edge where READY is seen high. That byte is returned together with a one-cycle acknowledge. Only the status code starts and ends a cycle, and wait states come from holding the state machine in T3/Tw. The bus controller derives its command strobes from the status code. Each T-state takes one `clk` cycle. One setup cycle, with the address valid and the status still passive, comes before T1.

Top module: `bus88_master`

## Requirements
- R1: After reset, `bus_status` is 7 (passive), `ad_oe`, `req_ack` and `busy` are 0, and `rd_data` is 0.
- R2: A request is taken only while `busy` is 0. In the cycle after it is taken there is a setup cycle. In that cycle `bus_status` is still 7, `bus_a_hi` carries address bits 19:16, `bus_a_mid` carries bits 15:8, and `ad_out` carries bits 7:0 with `ad_oe` high.
- R3: During T1, T2 and T3/Tw, `bus_status` equals the requested code. The codes are 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt, 4 instruction fetch, 5 memory read, 6 memory write and 7 passive.
- R4: In T1, `ad_out` carries address bits 7:0 with `ad_oe` high, whatever the code.
- R5: For codes 2 and 6, `ad_out` carries the write byte with `ad_oe` high in T2, T3/Tw and T4.
- R6: For every code other than 2 and 6, `ad_oe` is low from T2 until the bus is idle again.
- R7: READY is sampled on each clock edge in T3/Tw. Each low sample adds one more Tw cycle, with the status held.
- R8: The clock edge that samples READY high enters T4. In T4, `bus_status` is 7 and `req_ack` is high for exactly that one cycle. The next cycle is idle, with `busy` low.
- R9: For codes 1, 4 and 5, `rd_data` equals the `ad_in` value sampled on the edge that samples READY high, and it is valid while `req_ack` is high. Other codes leave `rd_data` unchanged.
- R10: While `busy` is high, `req_valid` is ignored: the address outputs and status of the running cycle do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_status | input | 3 | Status code of the requested cycle |
| req_addr | input | 20 | Transaction address |
| req_wdata | input | 8 | Write byte for codes 2 and 6 |
| req_ack | output | 1 | One-cycle completion pulse in T4 |
| rd_data | output | 8 | Captured read byte |
| busy | output | 1 | A cycle is in progress |
| bus_status | output | 3 | Status code to the bus controller |
| bus_a_hi | output | 4 | Address bits 19:16 |
| bus_a_mid | output | 8 | Address bits 15:8 |
| ad_out | output | 8 | Multiplexed address/data low byte |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Sampled value of the low byte bus |
| ready | input | 1 | Wait-state control from the bus |

## Verification
The assertions assume that `ready` and `ad_in` are stable around the sampling edge. They also assume that `req_status` is one of the eight defined codes whenever `req_valid` is high. The bench changes every input on the falling clock edge and only uses the defined codes. It raises `ready` only after the chosen number of low samples in T3/Tw. It also issues a competing request in the middle of a cycle, to show that such a request is dropped and not queued.

// File: rtl/bus88_pkg.sv
package bus88_pkg;

    parameter int unsigned ADDR_W = 20;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned CODE_W = 3;
    localparam int unsigned MID_W = 8;
    localparam int unsigned LO_W  = DATA_W;
    localparam int unsigned HI_W  = ADDR_W - MID_W - LO_W;

    typedef enum logic [CODE_W-1:0] {
        CODE_INTA    = 3'd0,
        CODE_IO_RD   = 3'd1,
        CODE_IO_WR   = 3'd2,
        CODE_HALT    = 3'd3,
        CODE_FETCH   = 3'd4,
        CODE_MEM_RD  = 3'd5,
        CODE_MEM_WR  = 3'd6,
        CODE_PASSIVE = 3'd7
    } bus_code_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_T1    = 3'd2,
        PH_T2    = 3'd3,
        PH_T3    = 3'd4,
        PH_T4    = 3'd5
    } phase_e;

    typedef struct packed {
        bus_code_e         code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic code_writes(bus_code_e c);
        return (c == CODE_IO_WR) || (c == CODE_MEM_WR);
    endfunction

    function automatic logic code_reads(bus_code_e c);
        return (c == CODE_IO_RD) || (c == CODE_FETCH) || (c == CODE_MEM_RD);
    endfunction

    function automatic logic phase_active(phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/bus88_seq.sv
module bus88_seq
    import bus88_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   ready,
    output phase_e phase,
    output logic   accept,
    output logic   capture
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (req_valid) phase_d = PH_SETUP;
            PH_SETUP: phase_d = PH_T1;
            PH_T1:    phase_d = PH_T2;
            PH_T2:    phase_d = PH_T3;
            PH_T3:    if (ready) phase_d = PH_T4;
            PH_T4:    phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase   = phase_q;
    assign accept  = (phase_q == PH_IDLE) && req_valid;
    assign capture = (phase_q == PH_T3) && ready;

    // R7: a low READY sample keeps the cycle in T3/Tw
    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_T3 && !ready) |=> (phase_q == PH_T3));

    // R8: a high READY sample moves to T4
    assert_ready_to_t4_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_T3 && ready) |=> (phase_q == PH_T4));

    // R2: every cycle starts with one setup cycle
    assert_setup_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && req_valid) |=> (phase_q == PH_SETUP));

endmodule

// File: rtl/bus88_req_reg.sv
module bus88_req_reg
    import bus88_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  bus_req_t req_d,
    output bus_req_t req_q
);

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '{code: CODE_PASSIVE, addr: '0, wdata: '0};
        else if (accept) req_q <= req_d;
    end

endmodule

// File: rtl/bus88_pins.sv
module bus88_pins
    import bus88_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  bus_req_t          req,
    output logic [CODE_W-1:0] status,
    output logic [HI_W-1:0]   a_hi,
    output logic [MID_W-1:0]  a_mid,
    output logic [LO_W-1:0]   ad_out,
    output logic              ad_oe
);

    assign status = phase_active(phase) ? req.code : CODE_PASSIVE;
    assign a_hi   = req.addr[ADDR_W-1 -: HI_W];
    assign a_mid  = req.addr[LO_W +: MID_W];

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        case (phase)
            PH_SETUP, PH_T1: begin
                ad_out = req.addr[LO_W-1:0];
                ad_oe  = 1'b1;
            end
            PH_T2, PH_T3, PH_T4: begin
                ad_out = req.wdata;
                ad_oe  = code_writes(req.code);
            end
            default: begin
                ad_out = '0;
                ad_oe  = 1'b0;
            end
        endcase
    end

    // R6: non-write cycles drive the low byte only for the address
    assert_no_data_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !code_writes(req.code)) |-> (phase == PH_SETUP || phase == PH_T1));

    // R3: status is held unchanged from T1 through T3/Tw
    assert_status_held_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2 || phase == PH_T3) |-> (status == $past(status)));

endmodule

// File: rtl/bus88_rdcap.sv
module bus88_rdcap
    import bus88_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  bus_code_e         code,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst)                             rd_data <= '0;
        else if (capture && code_reads(code)) rd_data <= ad_in;
    end

    // R9: non-read cycles leave the captured byte unchanged
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (capture && !code_reads(code)) |=> $stable(rd_data));

endmodule

// File: rtl/bus88_master.sv
module bus88_master
    import bus88_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_status,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [CODE_W-1:0] bus_status,
    output logic [HI_W-1:0]   bus_a_hi,
    output logic [MID_W-1:0]  bus_a_mid,
    output logic [LO_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [LO_W-1:0]   ad_in,
    input  logic              ready
);

    phase_e   phase;
    logic     accept;
    logic     capture;
    bus_req_t req_d;
    bus_req_t req_q;

    assign req_d = '{code: bus_code_e'(req_status), addr: req_addr, wdata: req_wdata};

    bus88_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (ready),
        .phase     (phase),
        .accept    (accept),
        .capture   (capture)
    );

    bus88_req_reg u_req (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req_d  (req_d),
        .req_q  (req_q)
    );

    bus88_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .req    (req_q),
        .status (bus_status),
        .a_hi   (bus_a_hi),
        .a_mid  (bus_a_mid),
        .ad_out (ad_out),
        .ad_oe  (ad_oe)
    );

    bus88_rdcap u_rd (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .code    (req_q.code),
        .ad_in   (ad_in),
        .rd_data (rd_data)
    );

    assign req_ack = (phase == PH_T4);
    assign busy    = (phase != PH_IDLE);

    // R8: acknowledge is a single-cycle pulse with passive status
    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);
    assert_ack_passive_R8: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (bus_status == CODE_PASSIVE));
    assert_ack_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ack) |-> $past(ready));

    // R10: a running cycle keeps its address regardless of req_valid
    assert_busy_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(bus_a_hi) && $stable(bus_a_mid)));

    // R1: passive status whenever idle
    assert_idle_passive_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_status == CODE_PASSIVE && !ad_oe));

endmodule

// File: tb/test_bus88_master.sv
module test_bus88_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_status;
    logic [19:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ack;
    logic [7:0]  rd_data;
    logic        busy;
    logic [2:0]  bus_status;
    logic [3:0]  bus_a_hi;
    logic [7:0]  bus_a_mid;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic        ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_rd = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus88_master i_bus88_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rd_data(rd_data), .busy(busy), .bus_status(bus_status),
        .bus_a_hi(bus_a_hi), .bus_a_mid(bus_a_mid), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_wr(input logic [2:0] c);
        return (c == 3'd2) || (c == 3'd6);
    endfunction

    function automatic bit is_rd(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd4) || (c == 3'd5);
    endfunction

    task automatic test_reset();
        rst = 1'b1; req_valid = 1'b0; req_status = 3'd7; req_addr = '0;
        req_wdata = '0; ad_in = '0; ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(bus_status == 3'd7, "R1 status", bus_status, 7);
        check(!ad_oe && !req_ack && !busy, "R1 oe/ack/busy", {ad_oe, req_ack, busy}, 0);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    endtask

    // one full cycle; intrude issues a competing request mid-cycle
    task automatic run_cycle(input logic [2:0] code, input logic [19:0] addr,
                             input logic [7:0] wd, input logic [7:0] rv,
                             input int nwait, input bit intrude);
        req_valid = 1'b1; req_status = code; req_addr = addr; req_wdata = wd;
        ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // setup cycle
        check(bus_status == 3'd7 && busy, "R2 setup status", bus_status, 7);
        check(bus_a_hi == addr[19:16], "R2 a_hi", bus_a_hi, addr[19:16]);
        check(bus_a_mid == addr[15:8], "R2 a_mid", bus_a_mid, addr[15:8]);
        check(ad_oe && ad_out == addr[7:0], "R2 ad low", ad_out, addr[7:0]);
        @(negedge clk);
        // T1
        check(bus_status == code, "R3 T1 status", bus_status, code);
        check(ad_oe && ad_out == addr[7:0], "R4 T1 ad", {ad_oe, ad_out}, {1'b1, addr[7:0]});
        @(negedge clk);
        // T2
        check(bus_status == code, "R3 T2 status", bus_status, code);
        check(ad_oe == is_wr(code), "R5/R6 T2 oe", ad_oe, is_wr(code));
        if (is_wr(code)) check(ad_out == wd, "R5 T2 data", ad_out, wd);
        ready = 1'b0;
        if (intrude) begin
            req_valid = 1'b1; req_status = 3'd3; req_addr = ~addr;
        end
        @(negedge clk);
        // T3
        req_valid = 1'b0;
        check(bus_status == code && !req_ack, "R3 T3 status", bus_status, code);
        check(ad_oe == is_wr(code), "R5/R6 T3 oe", ad_oe, is_wr(code));
        if (intrude) begin
            check(bus_a_hi == addr[19:16] && bus_a_mid == addr[15:8],
                  "R10 addr kept", {bus_a_hi, bus_a_mid}, addr[19:8]);
        end
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk);
            check(bus_status == code && !req_ack, "R7 Tw held", bus_status, code);
        end
        ready = 1'b1; ad_in = rv;
        @(negedge clk);
        // T4
        ready = 1'b0; ad_in = 8'h00;
        if (is_rd(code)) exp_rd = rv;
        check(bus_status == 3'd7, "R8 T4 passive", bus_status, 7);
        check(req_ack, "R8 ack", req_ack, 1);
        check(ad_oe == is_wr(code), "R5/R6 T4 oe", ad_oe, is_wr(code));
        if (is_wr(code)) check(ad_out == wd, "R5 T4 data", ad_out, wd);
        check(rd_data == exp_rd, "R9 rd_data", rd_data, exp_rd);
        if (intrude) check(bus_a_hi == addr[19:16], "R10 a_hi kept", bus_a_hi, addr[19:16]);
        @(negedge clk);
        // idle
        check(!req_ack && !busy && !ad_oe && bus_status == 3'd7, "R8 idle after T4",
              {req_ack, busy, ad_oe, bus_status}, 7);
    endtask

    task automatic test_mem_write();
        run_cycle(3'd6, 20'hA5C3E, 8'h5A, 8'hFF, 0, 1'b0);
    endtask

    task automatic test_io_write_waits();
        run_cycle(3'd2, 20'h003F8, 8'hC7, 8'h11, 3, 1'b0);
    endtask

    task automatic test_mem_read();
        run_cycle(3'd5, 20'hF0123, 8'h00, 8'h96, 0, 1'b0);
    endtask

    task automatic test_fetch_waits();
        run_cycle(3'd4, 20'hFFFF0, 8'h00, 8'hEA, 2, 1'b0);
    endtask

    task automatic test_io_read();
        run_cycle(3'd1, 20'h00060, 8'h00, 8'h3C, 1, 1'b0);
    endtask

    task automatic test_halt_inta();
        run_cycle(3'd3, 20'h12345, 8'hAA, 8'h77, 0, 1'b0);
        run_cycle(3'd0, 20'h00000, 8'h55, 8'h88, 1, 1'b0);
    endtask

    task automatic test_busy_ignore();
        run_cycle(3'd6, 20'h9B7D1, 8'h42, 8'h00, 2, 1'b1);
    endtask

    initial begin
        test_reset();
        test_mem_write();
        test_io_write_waits();
        test_mem_read();
        test_fetch_waits();
        test_io_read();
        test_halt_inta();
        test_busy_ignore();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R8 actual=running expected=finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule